// File: doc/BRIEF.md
# Prioritized Interrupt Controller with Mask

This block gathers interrupt requests from a parameterized set of sources and forwards at most one of them to the processor. Each source owns a programmable 4-bit priority field written through a small configuration port. Every cycle the block finds the pending source with the largest priority value. Among sources with equal values, the one with the lowest source index wins. The winner's level is compared against the processor's current 4-bit interrupt mask. Only a level strictly above the mask is taken.

When a request is taken, the block registers the source index and its level and raises a request line to the processor. It also pulls an active-low external indication pin low. The held vector and level stay fixed until the processor acknowledges. The processor is expected to copy the reported level into its mask.

Sources are marked at build time as edge-sensed or not. Non-edge sources are level-sensed lines or internal peripheral requests. An edge-sensed source latches a pending flag on a rising input, and the acknowledge of its vector clears that flag. For a non-edge source, the indication pin returns high when the processor acknowledges. For an edge-sensed source, the pin stays low after the acknowledge and is released only by a separate exception-start strobe. If another request is taken while the pin is still waiting for release, the pin stays low.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, every priority field is 0, the processor request `cpuIrq` is 0, and `irqOutN` is 1.
- R2: A cycle with `cfgWrEn`=1 stores `cfgWrLvl` into the priority field of source `cfgWrIdx` at that clock edge. A field value of 0 keeps its source from ever being taken.
- R3: Among eligible requests, the source with the numerically largest priority field is selected.
- R4: When several eligible requests share the largest priority value, the lowest source index is selected.
- R5: A selected request is taken only if its priority value is strictly greater than `cpuMask`. Equal or lower values are ignored.
- R6: A request is taken in a cycle where `cpuIrq` is 0. At the next clock edge `cpuIrq` becomes 1, `irqOutN` becomes 0, and `vecNum`/`vecLvl` show the source index and its priority value. A non-edge source is eligible in the same cycle its input is high.
- R7: While `cpuIrq` is 1, `vecNum`, `vecLvl` and `cpuIrq` hold until a cycle with `cpuAck`=1. After that clock edge, `cpuIrq` is 0.
- R8: An edge-sensed source (bit i of `EDGE_MASK` set) latches a pending flag at the edge after its input goes from 0 to 1. The flag stays set after the input drops. The source becomes eligible one cycle later. The flag clears at the acknowledge of that source's vector.
- R9: When a non-edge vector is acknowledged, `irqOutN` returns to 1 at that clock edge.
- R10: When an edge-sensed vector is acknowledged, `irqOutN` stays 0. It returns to 1 at the edge of the first later cycle with `excStart`=1.
- R11: If a new request is taken in the same cycle that would release the pin, or while the pin is waiting for `excStart`, `irqOutN` stays 0.
- R12: `excStart` has no effect on `irqOutN` unless an acknowledged edge-sensed vector is waiting for release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfgWrEn | input | 1 | Priority field write strobe |
| cfgWrIdx | input | $clog2(NUM_SRC) | Source whose priority field is written |
| cfgWrLvl | input | LVL_W | Priority value to write |
| srcReq | input | NUM_SRC | Request inputs, one per source |
| cpuMask | input | LVL_W | Processor's current interrupt mask level |
| cpuAck | input | 1 | Processor accepts the held vector |
| excStart | input | 1 | Processor begins exception processing |
| cpuIrq | output | 1 | Request to the processor |
| irqOutN | output | 1 | Active-low external interrupt indication |
| vecNum | output | $clog2(NUM_SRC) | Index of the taken source |
| vecLvl | output | LVL_W | Priority value of the taken source |

## Verification
The bench builds the block with eight sources and 4-bit levels. Sources 4 to 7 are edge-sensed and sources 0 to 3 are non-edge. This places both release paths of the indication pin, and ties between the two source kinds, in one small instance. With eight sources, random priority writes produce frequent equal-level collisions. With 4-bit levels, the mask can be driven through every value, including the equal-level refusal at the top level 15.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic capture;  // latch winner into vector registers
    logic ackClr;   // held vector acknowledged, clear its pending flag
  } ctrlStrobe_t;

endpackage

// File: rtl/prio_irq_select.sv
module prio_irq_select #(
  parameter int NUM_SRC = 8,
  parameter int LVL_W   = 4,
  localparam int ID_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic [NUM_SRC-1:0]       effReq,
  input  logic [NUM_SRC*LVL_W-1:0] lvlFlat,
  output logic [ID_W-1:0]          winIdx,
  output logic [LVL_W-1:0]         winLvl
);

  // Ascending scan with strict compare: lowest index keeps a tie.
  always_comb begin
    winLvl = '0;
    winIdx = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (effReq[i] && (lvlFlat[i*LVL_W +: LVL_W] > winLvl)) begin
        winLvl = lvlFlat[i*LVL_W +: LVL_W];
        winIdx = ID_W'(i);
      end
    end
  end

endmodule

// File: rtl/prio_irq_datapath.sv
module prio_irq_datapath
  import prio_irq_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int LVL_W   = 4,
  parameter logic [NUM_SRC-1:0] EDGE_MASK = '0,
  localparam int ID_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfgWrEn,
  input  logic [ID_W-1:0]    cfgWrIdx,
  input  logic [LVL_W-1:0]   cfgWrLvl,
  input  logic [NUM_SRC-1:0] srcReq,
  input  logic [LVL_W-1:0]   cpuMask,
  input  ctrlStrobe_t        strb,
  output logic               candAccept,
  output logic               heldEdge,
  output logic [ID_W-1:0]    vecNum,
  output logic [LVL_W-1:0]   vecLvl
);

  logic [LVL_W-1:0]         prioReg [NUM_SRC];
  logic [NUM_SRC*LVL_W-1:0] lvlFlat;
  logic [NUM_SRC-1:0]       effReq;
  logic [ID_W-1:0]          winIdx;
  logic [LVL_W-1:0]         winLvl;
  logic [ID_W-1:0]          vecNumQ;
  logic [LVL_W-1:0]         vecLvlQ;

  for (genvar i = 0; i < NUM_SRC; i++) begin : gSrc
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        prioReg[i] <= '0;
      else if (cfgWrEn && (cfgWrIdx == ID_W'(i)))
        prioReg[i] <= cfgWrLvl;
    end
    assign lvlFlat[i*LVL_W +: LVL_W] = prioReg[i];

    assert_prio_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cfgWrEn && (cfgWrIdx == ID_W'(i))) |=> (prioReg[i] == $past(cfgWrLvl)));

    if (EDGE_MASK[i]) begin : gEdge
      logic prevQ;
      logic pendQ;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          prevQ <= 1'b0;
          pendQ <= 1'b0;
        end else begin
          prevQ <= srcReq[i];
          if (srcReq[i] && !prevQ)
            pendQ <= 1'b1;
          else if (strb.ackClr && (vecNumQ == ID_W'(i)))
            pendQ <= 1'b0;
        end
      end
      assign effReq[i] = pendQ;

      assert_edge_latch_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (srcReq[i] && !prevQ) |=> pendQ);
      assert_edge_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (strb.ackClr && (vecNumQ == ID_W'(i)) && !(srcReq[i] && !prevQ)) |=> !pendQ);
    end else begin : gLevel
      assign effReq[i] = srcReq[i];
    end
  end

  prio_irq_select #(
    .NUM_SRC (NUM_SRC),
    .LVL_W   (LVL_W)
  ) uSelect (
    .effReq  (effReq),
    .lvlFlat (lvlFlat),
    .winIdx  (winIdx),
    .winLvl  (winLvl)
  );

  // A zero level never exceeds any mask, so disabled sources are never taken
  assign candAccept = (winLvl > cpuMask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vecNumQ <= '0;
      vecLvlQ <= '0;
    end else if (strb.capture) begin
      vecNumQ <= winIdx;
      vecLvlQ <= winLvl;
    end
  end

  assign heldEdge = EDGE_MASK[vecNumQ];
  assign vecNum   = vecNumQ;
  assign vecLvl   = vecLvlQ;

  assert_capture_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
    strb.capture |=> (vecLvlQ > $past(cpuMask)));

endmodule

// File: rtl/prio_irq_control.sv
module prio_irq_control
  import prio_irq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        candAccept,
  input  logic        heldEdge,
  input  logic        cpuAck,
  input  logic        excStart,
  output ctrlStrobe_t strb,
  output logic        cpuIrq,
  output logic        irqOutN
);

  logic irqQ;
  logic pinQ;
  logic holdQ;   // edge vector acknowledged, waiting for exception start

  assign strb.capture = !irqQ && candAccept;
  assign strb.ackClr  = irqQ && cpuAck;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irqQ  <= 1'b0;
      pinQ  <= 1'b1;
      holdQ <= 1'b0;
    end else begin
      if (strb.capture)
        irqQ <= 1'b1;
      else if (strb.ackClr)
        irqQ <= 1'b0;

      if (strb.capture)
        pinQ <= 1'b0;
      else if (strb.ackClr && !heldEdge)
        pinQ <= 1'b1;
      else if (holdQ && excStart)
        pinQ <= 1'b1;

      if (strb.capture)
        holdQ <= 1'b0;
      else if (strb.ackClr && heldEdge)
        holdQ <= 1'b1;
      else if (excStart)
        holdQ <= 1'b0;
    end
  end

  assign cpuIrq  = irqQ;
  assign irqOutN = pinQ;

  assert_take_R6: assert property (@(posedge clk) disable iff (!rst_n)
    strb.capture |=> (irqQ && !pinQ));
  assert_level_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.ackClr && !heldEdge) |=> pinQ);
  assert_edge_wait_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.ackClr && heldEdge) |=> !pinQ);
  assert_hold_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (holdQ && !excStart) |=> !pinQ);
  assert_keep_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!pinQ && strb.capture) |=> !pinQ);
  assert_exc_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (excStart && !holdQ && !strb.capture && !strb.ackClr) |=> $stable(pinQ));

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import prio_irq_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int LVL_W   = 4,
  parameter logic [NUM_SRC-1:0] EDGE_MASK = 8'hF0,
  localparam int ID_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfgWrEn,
  input  logic [ID_W-1:0]    cfgWrIdx,
  input  logic [LVL_W-1:0]   cfgWrLvl,
  input  logic [NUM_SRC-1:0] srcReq,
  input  logic [LVL_W-1:0]   cpuMask,
  input  logic               cpuAck,
  input  logic               excStart,
  output logic               cpuIrq,
  output logic               irqOutN,
  output logic [ID_W-1:0]    vecNum,
  output logic [LVL_W-1:0]   vecLvl
);

  ctrlStrobe_t strb;
  logic        candAccept;
  logic        heldEdge;

  prio_irq_datapath #(
    .NUM_SRC   (NUM_SRC),
    .LVL_W     (LVL_W),
    .EDGE_MASK (EDGE_MASK)
  ) uDatapath (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfgWrEn    (cfgWrEn),
    .cfgWrIdx   (cfgWrIdx),
    .cfgWrLvl   (cfgWrLvl),
    .srcReq     (srcReq),
    .cpuMask    (cpuMask),
    .strb       (strb),
    .candAccept (candAccept),
    .heldEdge   (heldEdge),
    .vecNum     (vecNum),
    .vecLvl     (vecLvl)
  );

  prio_irq_control uControl (
    .clk        (clk),
    .rst_n      (rst_n),
    .candAccept (candAccept),
    .heldEdge   (heldEdge),
    .cpuAck     (cpuAck),
    .excStart   (excStart),
    .strb       (strb),
    .cpuIrq     (cpuIrq),
    .irqOutN    (irqOutN)
  );

  assert_hold_vec_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cpuIrq && !cpuAck) |=> (cpuIrq && $stable(vecNum) && $stable(vecLvl)));
  assert_ack_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cpuIrq && cpuAck) |=> !cpuIrq);
  assert_rise_above_mask_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpuIrq) |-> (vecLvl > $past(cpuMask)));

endmodule

// File: tb/prio_irq_ctrl_test.sv
`timescale 1ns/1ps
module prio_irq_ctrl_test;

  localparam int NUM = 8;
  localparam int LW  = 4;
  localparam int IW  = 3;
  localparam logic [NUM-1:0] EDGES = 8'hF0;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfgWrEn = 1'b0;
  logic [IW-1:0] cfgWrIdx = '0;
  logic [LW-1:0] cfgWrLvl = '0;
  logic [NUM-1:0] srcReq = '0;
  logic [LW-1:0] cpuMask = '1;
  logic          cpuAck = 1'b0;
  logic          excStart = 1'b0;
  logic          cpuIrq, irqOutN;
  logic [IW-1:0] vecNum;
  logic [LW-1:0] vecLvl;

  int checks = 0;
  int fails  = 0;
  string curTag = "R1";

  // reference state
  int mPrio [NUM];
  bit mPend [NUM];
  bit mPrev [NUM];
  bit mIrq, mPin, mHold;
  int mVec, mLvl;

  always #2.5 clk = ~clk;

  prio_irq_ctrl #(.NUM_SRC(NUM), .LVL_W(LW), .EDGE_MASK(EDGES)) uut (
    .clk(clk), .rst_n(rst_n), .cfgWrEn(cfgWrEn), .cfgWrIdx(cfgWrIdx),
    .cfgWrLvl(cfgWrLvl), .srcReq(srcReq), .cpuMask(cpuMask), .cpuAck(cpuAck),
    .excStart(excStart), .cpuIrq(cpuIrq), .irqOutN(irqOutN),
    .vecNum(vecNum), .vecLvl(vecLvl));

  function automatic bit isEdge(int i);
    return EDGES[i];
  endfunction

  // winner: highest level, lowest index on ties; returns {idx, lvl}
  function automatic void pickWinner(output int wIdx, output int wLvl);
    wIdx = 0; wLvl = 0;
    for (int i = 0; i < NUM; i++) begin
      bit e;
      e = isEdge(i) ? mPend[i] : srcReq[i];
      if (e && mPrio[i] > wLvl) begin wLvl = mPrio[i]; wIdx = i; end
    end
  endfunction

  task automatic expectVal(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic modelReset();
    for (int i = 0; i < NUM; i++) begin mPrio[i] = 0; mPend[i] = 0; mPrev[i] = 0; end
    mIrq = 0; mPin = 1; mHold = 0; mVec = 0; mLvl = 0;
  endtask

  // advance one clock: model next state, edge, compare outputs
  task automatic step();
    int wIdx, wLvl;
    bit accept, ack;
    pickWinner(wIdx, wLvl);
    accept = !mIrq && (wLvl > int'(cpuMask));
    ack = mIrq && cpuAck;
    for (int i = 0; i < NUM; i++) begin
      if (isEdge(i)) begin
        if (srcReq[i] && !mPrev[i]) mPend[i] = 1;
        else if (ack && mVec == i) mPend[i] = 0;
      end
      mPrev[i] = srcReq[i];
    end
    if (accept) mPin = 0;
    else if (ack && !isEdge(mVec)) mPin = 1;
    else if (mHold && excStart) mPin = 1;
    if (accept) mHold = 0;
    else if (ack && isEdge(mVec)) mHold = 1;
    else if (excStart) mHold = 0;
    if (accept) begin mIrq = 1; mVec = wIdx; mLvl = wLvl; end
    else if (ack) mIrq = 0;
    if (cfgWrEn) mPrio[cfgWrIdx] = cfgWrLvl;
    @(posedge clk);
    #1;
    checks++;
    if (cpuIrq !== mIrq || irqOutN !== mPin ||
        (mIrq && (int'(vecNum) != mVec || int'(vecLvl) != mLvl))) begin
      fails++;
      $display("FAIL %s: actual irq=%0b pin=%0b vec=%0d lvl=%0d expected irq=%0b pin=%0b vec=%0d lvl=%0d",
               curTag, cpuIrq, irqOutN, vecNum, vecLvl, mIrq, mPin, mVec, mLvl);
    end
    @(negedge clk);
    cfgWrEn = 0; cpuAck = 0; excStart = 0;
  endtask

  task automatic writePrio(int idx, int lvl);
    cfgWrEn = 1; cfgWrIdx = IW'(idx); cfgWrLvl = LW'(lvl);
    step();
  endtask

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    modelReset();
    repeat (4) @(negedge clk);
    rst_n = 1;
    #0;
    curTag = "R1";
    expectVal("R1 cpuIrq after reset", cpuIrq, 0);
    expectVal("R1 irqOutN after reset", irqOutN, 1);

    // zero priorities never taken
    curTag = "R2 zero level";
    srcReq = 8'h0F; cpuMask = 0;
    repeat (3) step();
    expectVal("R2 zero level disables", cpuIrq, 0);
    srcReq = 0; cpuMask = 15; step();

    // tie and strict mask
    curTag = "R2 write";
    writePrio(2, 5);
    writePrio(3, 5);
    curTag = "R5 equal refused";
    srcReq = 8'h0C; cpuMask = 5; step();
    expectVal("R5 equal level ignored", cpuIrq, 0);
    curTag = "R4 tie";
    cpuMask = 4; step();
    expectVal("R6 request raised", cpuIrq, 1);
    expectVal("R4 lowest index wins tie", vecNum, 2);
    expectVal("R6 level reported", vecLvl, 5);
    expectVal("R6 pin low", irqOutN, 0);
    curTag = "R12 excStart no hold";
    excStart = 1; srcReq = 8'h08; cpuMask = 0; step();
    expectVal("R12 pin unaffected", irqOutN, 0);
    expectVal("R7 vector held", vecNum, 2);
    curTag = "R9 level release";
    cpuAck = 1; cpuMask = 15; step();
    expectVal("R7 cpuIrq drops", cpuIrq, 0);
    expectVal("R9 pin released", irqOutN, 1);
    srcReq = 0; step();

    // highest level wins
    curTag = "R3 highest";
    writePrio(1, 9);
    srcReq = 8'h06; cpuMask = 4; step();
    expectVal("R3 highest level wins", vecNum, 1);
    expectVal("R3 level 9", vecLvl, 9);
    cpuAck = 1; srcReq = 0; cpuMask = 15; step();

    // edge source release via excStart
    curTag = "R8 edge";
    writePrio(5, 7);
    srcReq = 8'h20; step();
    srcReq = 0; step();
    cpuMask = 6; step();
    expectVal("R8 latched edge taken", vecNum, 5);
    curTag = "R10 edge wait";
    cpuAck = 1; step();
    expectVal("R10 pin held low after ack", irqOutN, 0);
    step();
    expectVal("R8 pending cleared", cpuIrq, 0);
    excStart = 1; step();
    expectVal("R10 released by excStart", irqOutN, 1);
    excStart = 1; step();
    expectVal("R12 excStart idle", irqOutN, 1);

    // new take while waiting
    curTag = "R11 keep low";
    cpuMask = 15; srcReq = 8'h20; step();
    srcReq = 0; cpuMask = 6; step();
    cpuAck = 1; cpuMask = 15; step();
    srcReq = 8'h02; cpuMask = 8; excStart = 1; step();
    expectVal("R11 pin stays low", irqOutN, 0);
    expectVal("R11 new vector", vecNum, 1);
    cpuAck = 1; srcReq = 0; cpuMask = 15; step();
    expectVal("R9 released after level ack", irqOutN, 1);

    // random mix
    curTag = "R3 R4 R5 R7 R8 random";
    void'($urandom(32'h5eed_1234));
    for (int n = 0; n < 4000; n++) begin
      if ($urandom_range(0, 7) == 0) begin
        cfgWrEn = 1; cfgWrIdx = IW'($urandom_range(0, NUM-1));
        cfgWrLvl = LW'($urandom_range(0, 15));
      end
      srcReq = NUM'($urandom & $urandom);
      cpuMask = LW'($urandom_range(0, 15));
      cpuAck = mIrq && ($urandom_range(0, 2) == 0);
      excStart = ($urandom_range(0, 5) == 0);
      step();
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule